// File: doc/BRIEF.md
# Multiplexed Converter Channel Sequencer

This controller drives a multiplexed oversampling converter through a set of enabled input channels. For each channel it selects the multiplexer input and presents that channel's filter order. It resets the decimation filter, waits out a programmable settling interval, and then lets the filter run long enough to flush its latency. Only then does it raise a one-cycle result strobe tagged with the channel index. The intermediate filter outputs that precede the settled one are never flagged.

Three run styles are selected by a mode input.
- Continuous scanning wraps from the highest enabled channel back to the lowest.
- Duty-cycled scanning follows every pass with a standby interval three or fifteen times the length of the pass. The converter is therefore active for one quarter or one sixteenth of the time.
- Triggered scanning waits in standby for a sync pulse, runs exactly one pass, and drops back to standby.

One clock cycle of this block equals one modulator clock.

Top module: `chan_scan_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `standby` is 1, `resultValid` and `filtRst` are 0 and `muxSel` is 0.
- R2: Mode 2'b00 is continuous: enabled channels (bit i of `chanEn` enables channel i) are visited in ascending index order, and the scan wraps to the lowest enabled channel with no standby cycle in between.
- R3: The settle interval of channel i is the 16-bit field `chanSettle[16*i +: 16]` in clock cycles. Any value below 4 is raised to 4.
- R4: Bit i of `chanFilt` selects the filter order of channel i, with 0 for third order and 1 for fourth order. After settling, the result comes 3 or 4 conversion periods of 8 cycles later, so 24 or 32 cycles. `filtType` shows the selected channel's bit.
- R5: Each channel visit yields exactly one one-cycle `resultValid` pulse, with `resultChan` equal to that channel. In continuous mode the spacing between consecutive pulses is the settle interval plus the filter latency of the later channel.
- R6: `filtRst` is high for exactly one cycle, in the first settle cycle of every channel visit.
- R7: Mode 2'b01 and mode 2'b10 are duty-cycled. After each pass of A active cycles, `standby` is held for 3*A cycles (mode 2'b01) or 15*A cycles (mode 2'b10), and then the next pass begins.
- R8: Mode 2'b11 is triggered. The block idles in standby. A cycle with `syncIn` high starts one pass: the first channel's settle starts in the following cycle. When the pass ends, the block returns to standby and stays there.
- R9: In mode 2'b11, a `syncIn` pulse that arrives while a pass is running has no effect: each accepted pulse yields exactly one pass.
- R10: With no channel enabled, the block stays in standby and emits no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rstN | input | 1 | Synchronous active-low reset |
| runMode | input | 2 | 00 continuous, 01 quarter duty, 10 sixteenth duty, 11 triggered |
| syncIn | input | 1 | Starts one pass in triggered mode |
| chanEn | input | 16 | Channel enable bitmap |
| chanSettle | input | 256 | Per-channel settle counts, 16 bits each |
| chanFilt | input | 16 | Per-channel filter order (1 = fourth order) |
| muxSel | output | 4 | Selected multiplexer input |
| filtType | output | 1 | Filter order of the selected channel |
| filtRst | output | 1 | One-cycle filter reset at each channel change |
| standby | output | 1 | Converter standby request |
| resultValid | output | 1 | Settled result available |
| resultChan | output | 4 | Channel of the settled result |

## Verification
The embedded properties assume that `chanEn`, `chanSettle` and `chanFilt` are stable while the block is out of reset, because the filter order shown must change only at a channel switch. The stimulus therefore writes all configuration only while reset is asserted, and it reconfigures between scenarios by going back through reset. The mode input is held constant within a scenario, and sync pulses last a single cycle and are driven away from the clock edge.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_SLEEP  = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_DUTY4  = 2'b01,
    MODE_DUTY16 = 2'b10,
    MODE_SYNC   = 2'b11
  } runMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldFirst;   // load lowest enabled channel, start a pass
    logic ldNext;    // load next higher enabled channel
    logic ldConv;    // settle done, load filter latency count
    logic ldSleep;   // pass done, load standby count
    logic cntActive; // count an active cycle
  } seqCmd_t;

endpackage

// File: rtl/chan_scan_dp.sv
module chan_scan_dp
  import chan_scan_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int SETTLE_W    = 16,
  parameter int MIN_SETTLE  = 4,
  parameter int CONV_CYCLES = 8,
  localparam int CH_W   = $clog2(NCH),
  localparam int CONV_W = $clog2(4 * CONV_CYCLES + 1),
  localparam int TICK_W = (SETTLE_W > CONV_W) ? SETTLE_W : CONV_W,
  localparam int ACT_W  = TICK_W + CH_W + 1,
  localparam int SLP_W  = ACT_W + 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqCmd_t                   cmd,
  input  logic [1:0]                mode,
  input  logic [NCH-1:0]            chanEn,
  input  logic [NCH*SETTLE_W-1:0]   chanSettle,
  input  logic [NCH-1:0]            chanFilt,
  output logic [CH_W-1:0]           curChan,
  output logic                      curFilt,
  output logic                      filtRst,
  output logic                      tickZero,
  output logic                      sleepZero,
  output logic                      hasHigher,
  output logic                      anyEn
);

  logic [CH_W-1:0]     higherIdx, firstIdx, loadIdx;
  logic [SETTLE_W-1:0] rawSettle, settleLim;
  logic [TICK_W-1:0]   tick, convLen;
  logic [ACT_W-1:0]    activeCnt;
  logic [SLP_W-1:0]    sleepCnt, sleepLen, activeTotal;
  logic                rstPend;

  // lowest enabled channel overall and lowest one above the current channel
  always_comb begin
    hasHigher = 1'b0;
    anyEn     = 1'b0;
    higherIdx = '0;
    firstIdx  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (chanEn[i]) begin
        anyEn    = 1'b1;
        firstIdx = CH_W'(i);
        if (i > int'(curChan)) begin
          hasHigher = 1'b1;
          higherIdx = CH_W'(i);
        end
      end
    end
  end

  assign loadIdx   = cmd.ldFirst ? firstIdx : higherIdx;
  assign rawSettle = chanSettle[int'(loadIdx) * SETTLE_W +: SETTLE_W];
  assign settleLim = (rawSettle < SETTLE_W'(MIN_SETTLE)) ? SETTLE_W'(MIN_SETTLE) : rawSettle;
  assign curFilt   = chanFilt[curChan];
  assign convLen   = curFilt ? TICK_W'(4 * CONV_CYCLES) : TICK_W'(3 * CONV_CYCLES);

  assign activeTotal = SLP_W'(activeCnt) + SLP_W'(1);
  assign sleepLen    = (mode == MODE_DUTY16) ? activeTotal * SLP_W'(15)
                                             : activeTotal * SLP_W'(3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curChan   <= '0;
      tick      <= '0;
      rstPend   <= 1'b0;
      activeCnt <= '0;
      sleepCnt  <= '0;
    end else begin
      rstPend <= 1'b0;
      if (cmd.ldFirst || cmd.ldNext) begin
        curChan <= loadIdx;
        tick    <= TICK_W'(settleLim) - TICK_W'(1);
        rstPend <= 1'b1;
      end else if (cmd.ldConv) begin
        tick <= convLen - TICK_W'(1);
      end else if (tick != '0) begin
        tick <= tick - TICK_W'(1);
      end

      if (cmd.ldFirst)        activeCnt <= '0;
      else if (cmd.cntActive) activeCnt <= activeCnt + ACT_W'(1);

      if (cmd.ldSleep)            sleepCnt <= sleepLen - SLP_W'(1);
      else if (sleepCnt != '0)    sleepCnt <= sleepCnt - SLP_W'(1);
    end
  end

  assign tickZero  = (tick == '0);
  assign sleepZero = (sleepCnt == '0);
  assign filtRst   = rstPend;

  // R6: the filter reset never stretches past one cycle
  p_rst_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    filtRst |=> !filtRst);

  // R4: the presented filter order only moves together with a channel change
  p_filt_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !filtRst |-> $stable(curFilt));

endmodule

// File: rtl/chan_scan_ctrl.sv
module chan_scan_ctrl
  import chan_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       syncIn,
  input  logic       tickZero,
  input  logic       sleepZero,
  input  logic       hasHigher,
  input  logic       anyEn,
  output seqCmd_t    cmd,
  output logic       standby,
  output logic       resultValid
);

  seqState_t state, nextState;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (anyEn && (mode != MODE_SYNC || syncIn)) begin
          cmd.ldFirst = 1'b1;
          nextState   = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        cmd.cntActive = 1'b1;
        if (tickZero) begin
          cmd.ldConv = 1'b1;
          nextState  = ST_CONV;
        end
      end
      ST_CONV: begin
        cmd.cntActive = 1'b1;
        if (tickZero) begin
          if (hasHigher) begin
            cmd.ldNext = 1'b1;
            nextState  = ST_SETTLE;
          end else if (mode == MODE_CONT && anyEn) begin
            cmd.ldFirst = 1'b1;
            nextState   = ST_SETTLE;
          end else if (mode == MODE_DUTY4 || mode == MODE_DUTY16) begin
            cmd.ldSleep = 1'b1;
            nextState   = ST_SLEEP;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_SLEEP: begin
        if (sleepZero) begin
          if (anyEn && mode != MODE_SYNC) begin
            cmd.ldFirst = 1'b1;
            nextState   = ST_SETTLE;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign standby     = (state == ST_IDLE) || (state == ST_SLEEP);
  assign resultValid = (state == ST_CONV) && tickZero;

  // R5: results only while converting, and never two cycles in a row
  p_valid_in_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !standby);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int SETTLE_W    = 16,
  parameter int MIN_SETTLE  = 4,
  parameter int CONV_CYCLES = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              runMode,
  input  logic                    syncIn,
  input  logic [NCH-1:0]          chanEn,
  input  logic [NCH*SETTLE_W-1:0] chanSettle,
  input  logic [NCH-1:0]          chanFilt,
  output logic [CH_W-1:0]         muxSel,
  output logic                    filtType,
  output logic                    filtRst,
  output logic                    standby,
  output logic                    resultValid,
  output logic [CH_W-1:0]         resultChan
);

  seqCmd_t cmd;
  logic    tickZero, sleepZero, hasHigher, anyEn;

  chan_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(runMode), .syncIn(syncIn),
    .tickZero(tickZero), .sleepZero(sleepZero), .hasHigher(hasHigher),
    .anyEn(anyEn), .cmd(cmd), .standby(standby), .resultValid(resultValid)
  );

  chan_scan_dp #(
    .NCH(NCH), .SETTLE_W(SETTLE_W), .MIN_SETTLE(MIN_SETTLE), .CONV_CYCLES(CONV_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .mode(runMode), .chanEn(chanEn),
    .chanSettle(chanSettle), .chanFilt(chanFilt), .curChan(muxSel),
    .curFilt(filtType), .filtRst(filtRst), .tickZero(tickZero),
    .sleepZero(sleepZero), .hasHigher(hasHigher), .anyEn(anyEn)
  );

  assign resultChan = muxSel;

  // R8: while parked in standby the multiplexer does not move
  p_mux_still_standby_r8: assert property (@(posedge clk) disable iff (!rstN)
    (standby && $past(standby)) |-> $stable(muxSel));

endmodule

// File: tb/chan_scan_seq_test.sv
module chan_scan_seq_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   runMode = 2'b00;
  logic         syncIn = 1'b0;
  logic [15:0]  chanEn = '0;
  logic [255:0] chanSettle = '0;
  logic [15:0]  chanFilt = '0;
  logic [3:0]   muxSel, resultChan;
  logic         filtType, filtRst, standby, resultValid;

  int checks = 0;
  int fails = 0;
  int cycleCount = 0;
  int evCount, rstCount, stbyRun;
  int evTime[64];
  int evChan[64];
  int evFilt[64];
  int evStby[64];
  int rstTime[64];

  chan_scan_seq uut (
    .clk(clk), .rstN(rstN), .runMode(runMode), .syncIn(syncIn),
    .chanEn(chanEn), .chanSettle(chanSettle), .chanFilt(chanFilt),
    .muxSel(muxSel), .filtType(filtType), .filtRst(filtRst),
    .standby(standby), .resultValid(resultValid), .resultChan(resultChan)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  // event log, sampled away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      evCount = 0; rstCount = 0; stbyRun = 0;
    end else begin
      if (standby) stbyRun = stbyRun + 1;
      if (filtRst && rstCount < 64) begin
        rstTime[rstCount] = cycleCount;
        rstCount = rstCount + 1;
      end
      if (resultValid && evCount < 64) begin
        evTime[evCount] = cycleCount;
        evChan[evCount] = int'(resultChan);
        evFilt[evCount] = int'(filtType);
        evStby[evCount] = stbyRun;
        stbyRun = 0;
        evCount = evCount + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic applyReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0;
    runMode = m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setSettle(input int ch, input int val);
    chanSettle[ch*16 +: 16] = 16'(val);
  endtask

  task automatic clearCfg();
    chanEn = '0; chanSettle = '0; chanFilt = '0;
  endtask

  task automatic waitEvents(input int n, input int limit);
    for (int i = 0; i < limit && evCount < n; i++) @(negedge clk);
  endtask

  task automatic pulseSync(output int when);
    @(negedge clk);
    syncIn = 1'b1;
    when = cycleCount;
    @(negedge clk);
    syncIn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    clearCfg();
    runMode = 2'b00;
    repeat (2) @(negedge clk);
    check("R1 standby in reset", int'(standby), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 standby after reset", int'(standby), 1);
    check("R1 resultValid after reset", int'(resultValid), 0);
    check("R1 filtRst after reset", int'(filtRst), 0);
    check("R1 muxSel after reset", int'(muxSel), 0);
    repeat (100) @(negedge clk);
    check("R10 no result with empty bitmap", evCount, 0);
    check("R10 standby with empty bitmap", int'(standby), 1);
  endtask

  function automatic int contGap(input int ch);
    // R3 clamp and R4 latency: ch1 10+24, ch4 4+32, ch9 4+24
    if (ch == 1) return 34;
    if (ch == 4) return 36;
    return 28;
  endfunction

  task automatic testContinuous();
    int order[7] = '{1, 4, 9, 1, 4, 9, 1};
    @(negedge clk);
    rstN = 1'b0;
    clearCfg();
    chanEn[1] = 1'b1; chanEn[4] = 1'b1; chanEn[9] = 1'b1;
    setSettle(1, 10); setSettle(4, 2); setSettle(9, 0);
    chanFilt[4] = 1'b1;
    applyReset(2'b00);
    waitEvents(7, 2000);
    check("R2 event count", evCount, 7);
    check("R6 reset pulse count", rstCount, 7);
    for (int k = 0; k < 7; k++) begin
      check("R2 scan order", evChan[k], order[k]);
      check("R4 filter order shown", evFilt[k], (order[k] == 4) ? 1 : 0);
    end
    for (int k = 1; k < 7; k++) begin
      check("R3 R5 result spacing", evTime[k] - evTime[k-1], contGap(order[k]));
      check("R2 no standby in wrap", evStby[k], 0);
    end
    for (int k = 0; k < 6; k++)
      check("R6 reset at channel change", rstTime[k+1], evTime[k] + 1);
  endtask

  task automatic testDuty(input logic [1:0] m, input int mult);
    @(negedge clk);
    rstN = 1'b0;
    clearCfg();
    chanEn[2] = 1'b1;
    setSettle(2, 6);
    applyReset(m);
    waitEvents(3, 3000);
    check("R7 duty event count", evCount, 3);
    for (int k = 1; k < 3; k++) begin
      check("R7 duty period", evTime[k] - evTime[k-1], 30 + 30 * mult);
      check("R7 standby length", evStby[k], 30 * mult);
    end
  endtask

  task automatic testDutyTwo();
    @(negedge clk);
    rstN = 1'b0;
    clearCfg();
    chanEn[2] = 1'b1; chanEn[3] = 1'b1;
    setSettle(2, 6); setSettle(3, 4);
    chanFilt[3] = 1'b1;
    applyReset(2'b01);
    waitEvents(4, 3000);
    check("R7 two-channel count", evCount, 4);
    check("R7 inside pass", evTime[1] - evTime[0], 36);
    check("R7 across standby", evTime[2] - evTime[1], 198 + 30);
    check("R7 standby two-channel", evStby[2], 198);
    check("R7 no standby inside pass", evStby[3], 0);
  endtask

  task automatic testSync();
    int t0;
    int t1;
    @(negedge clk);
    rstN = 1'b0;
    clearCfg();
    chanEn[0] = 1'b1; chanEn[5] = 1'b1;
    setSettle(0, 20); setSettle(5, 0);
    chanFilt[5] = 1'b1;
    applyReset(2'b11);
    repeat (50) @(negedge clk);
    check("R8 waits for sync", evCount, 0);
    check("R8 standby before sync", int'(standby), 1);
    pulseSync(t0);
    waitEvents(2, 500);
    check("R8 first result latency", evTime[0] - t0, 44);
    check("R8 second channel", evChan[1], 5);
    check("R8 second spacing", evTime[1] - evTime[0], 36);
    @(negedge clk);
    check("R8 back to standby", int'(standby), 1);
    repeat (200) @(negedge clk);
    check("R8 single pass only", evCount, 2);
    pulseSync(t1);
    repeat (8) @(negedge clk);
    check("R9 pass running", int'(standby), 0);
    pulseSync(t0);
    repeat (400) @(negedge clk);
    check("R9 sync during pass ignored", evCount, 4);
    check("R9 pass timing kept", evTime[2] - t1, 44);
    check("R9 standby after pass", int'(standby), 1);
    pulseSync(t0);
    repeat (200) @(negedge clk);
    check("R8 later sync accepted", evCount, 6);
  endtask

  initial begin : watchdog
    wait (cycleCount > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycleCount, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testContinuous();
    testDuty(2'b01, 3);
    testDuty(2'b10, 15);
    testDutyTwo();
    testSync();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule